// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block owns the bus-clock enables for sixteen peripherals. Software turns each peripheral's clock on or off by writing one bit in one of two 8-bit gating registers. Each enable comes straight from a flop, so the clock-gate cells downstream see a clean level that changes only at a clock edge. After reset every clock is off.

The same block sits on the peripheral side of the bus decode. It turns the upper address bits into a peripheral select and qualifies that select with the peripheral's enable bit. A write aimed at a peripheral whose clock is off never reaches it. A read from such a peripheral returns zero. Both gating registers can be read back.

Top module: `pclk_gate_top`

## Requirements
- R1: After reset all sixteen clock enables are 0, and both gating registers read back as 0.
- R2: A write to gating register offset 0 loads enables 7:0 and a write to offset 1 loads enables 15:8. Data bit i enables peripheral 8*offset+i. The new value is visible on `periphClkEn` from the clock edge that accepts the write, so it shows in the very next cycle.
- R3: A read with address bit 7 set returns the current contents of the gating register that the offset selects.
- R4: A write with address bit 7 clear pulses only the `periphWrEn` bit of the peripheral that bits 6:3 index, and only while that peripheral's enable is 1.
- R5: A write to a peripheral whose enable is 0 is discarded, so all bits of `periphWrEn` stay 0.
- R6: A peripheral read returns that peripheral's `periphRdData` slice when its enable is 1, and 0 when its enable is 0. `busRdData` is 0 in any cycle without a read.
- R7: `periphSel` has at most one bit set. That bit is set only during a peripheral read or write, and only for an enabled peripheral.
- R8: Address bit 7 chooses control space (1) or peripheral space (0). In control space only bit 0 picks the gating register, and bits 6:1 are ignored.
- R9: A write to one gating register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Access address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data returned to the bus |
| periphRdData | input | 128 | Read data from the peripherals, 8 bits each, peripheral 0 in the low byte |
| periphSel | output | 16 | Select qualified by the enables |
| periphWrEn | output | 16 | Write strobe qualified by the enables |
| periphClkEn | output | 16 | Registered clock enable for each peripheral |

## Verification
The assertions assume that `busWrEn` and `busRdEn` are never high together and that the address is stable for the whole cycle in which a strobe is high. The bench drives exactly one strobe, or none, per cycle and changes the inputs only at the falling edge. Under those conditions the one-hot check on the select and the check that a read of a disabled peripheral returns zero are meaningful. The register-update checks compare the registers against the data captured one edge earlier, which the stimulus always presents together with the write strobe.

// File: rtl/pclk_gate_pkg.sv
package pclk_gate_pkg;

  // Decoded strobes passed from the address decoder to the datapath
  typedef struct packed {
    logic       ctrlWr;    // write into a gating register
    logic       ctrlRd;    // read of a gating register
    logic       periphWr;  // write aimed at peripheral space
    logic       periphRd;  // read aimed at peripheral space
    logic [7:0] regIdx;    // gating register offset
    logic [7:0] periphIdx; // peripheral index
  } gateStrb_t;

endpackage

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pclk_gate_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PERIPH = 16,
  parameter int DATA_W     = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output gateStrb_t         strb
);

  localparam int IDX_W     = $clog2(NUM_PERIPH);
  localparam int NUM_REGS  = NUM_PERIPH / DATA_W;
  localparam int REG_SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             ctrlSpace;
  logic [IDX_W-1:0] idx;
  logic [REG_SEL_W-1:0] regSel;

  assign ctrlSpace = busAddr[ADDR_W-1];
  assign idx       = busAddr[ADDR_W-2 -: IDX_W];
  assign regSel    = busAddr[REG_SEL_W-1:0];

  always_comb begin
    strb           = '0;
    strb.ctrlWr    = busWrEn & ctrlSpace;
    strb.ctrlRd    = busRdEn & ctrlSpace;
    strb.periphWr  = busWrEn & ~ctrlSpace;
    strb.periphRd  = busRdEn & ~ctrlSpace;
    strb.regIdx    = 8'(regSel);
    strb.periphIdx = 8'(idx);
  end

endmodule

// File: rtl/pclk_gate_dp.sv
module pclk_gate_dp
  import pclk_gate_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  gateStrb_t                    strb,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic [NUM_PERIPH*DATA_W-1:0] periphRdData,
  output logic [DATA_W-1:0]            busRdData,
  output logic [NUM_PERIPH-1:0]        periphSel,
  output logic [NUM_PERIPH-1:0]        periphWrEn,
  output logic [NUM_PERIPH-1:0]        periphClkEn
);

  localparam int IDX_W     = $clog2(NUM_PERIPH);
  localparam int NUM_REGS  = NUM_PERIPH / DATA_W;
  localparam int REG_SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] gateRegs;
  logic [IDX_W-1:0]                pIdx;
  logic [REG_SEL_W-1:0]            rIdx;

  assign pIdx = strb.periphIdx[IDX_W-1:0];
  assign rIdx = strb.regIdx[REG_SEL_W-1:0];

  // Gating registers: enables come straight from flops, so they cannot glitch
  for (genvar r = 0; r < NUM_REGS; r++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        gateRegs[r] <= '0;
      else if (strb.ctrlWr && rIdx == REG_SEL_W'(r))
        gateRegs[r] <= busWrData;
    end

    assert_other_reg_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ctrlWr && rIdx != REG_SEL_W'(r)) |=> $stable(gateRegs[r]));
  end

  assign periphClkEn = gateRegs;

  // Select and write filtering: decoded select ANDed with the enable bit
  for (genvar p = 0; p < NUM_PERIPH; p++) begin : gSel
    logic hit;
    assign hit           = (pIdx == IDX_W'(p));
    assign periphSel[p]  = hit & (strb.periphWr | strb.periphRd) & periphClkEn[p];
    assign periphWrEn[p] = hit & strb.periphWr & periphClkEn[p];
  end

  // Read return path
  always_comb begin
    busRdData = '0;
    if (strb.ctrlRd)
      busRdData = gateRegs[rIdx];
    else if (strb.periphRd && periphClkEn[pIdx])
      busRdData = periphRdData[int'(pIdx)*DATA_W +: DATA_W];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> periphClkEn == '0);

  assert_write_effect_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> gateRegs[$past(rIdx)] == $past(busWrData));

  assert_wr_only_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    (periphWrEn & ~periphClkEn) == '0);

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(periphSel));

  assert_rd_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.periphRd && !periphClkEn[pIdx]) |-> busRdData == '0);

endmodule

// File: rtl/pclk_gate_top.sv
module pclk_gate_top
  import pclk_gate_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PERIPH = 16,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  output logic [DATA_W-1:0]            busRdData,
  input  logic [NUM_PERIPH*DATA_W-1:0] periphRdData,
  output logic [NUM_PERIPH-1:0]        periphSel,
  output logic [NUM_PERIPH-1:0]        periphWrEn,
  output logic [NUM_PERIPH-1:0]        periphClkEn
);

  gateStrb_t strb;

  pclk_gate_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)
  ) uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  pclk_gate_dp #(
    .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .periphRdData(periphRdData), .busRdData(busRdData),
    .periphSel(periphSel), .periphWrEn(periphWrEn), .periphClkEn(periphClkEn)
  );

endmodule

// File: tb/tb_pclk_gate_top.sv
module tb_pclk_gate_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  rd;
    logic [15:0] sel;
    logic [15:0] wr;
    logic [15:0] en;
    string       tag;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWrEn = 0;
  logic busRdEn = 0;
  logic [7:0] busRdData;
  logic [127:0] periphRdData;
  logic [15:0] periphSel, periphWrEn, periphClkEn;

  expItem_t scoreQ[$];
  logic [15:0] modelEn = '0;
  int vecCount = 0;
  int failCount = 0;
  bit finished = 0;
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_gate_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .periphRdData(periphRdData), .periphSel(periphSel),
    .periphWrEn(periphWrEn), .periphClkEn(periphClkEn)
  );

  function automatic logic [7:0] periphVal(int i);
    return 8'hA0 + 8'(i);
  endfunction

  // Driver: apply one bus cycle and push the expected result
  task automatic applyVec(input logic [7:0] addr, input logic [7:0] wd,
                          input logic we, input logic re, input string tag);
    expItem_t it;
    logic ctrl;
    int idx;
    @(negedge clk);
    busAddr = addr; busWrData = wd; busWrEn = we; busRdEn = re;
    ctrl = addr[7];
    idx  = int'(addr[6:3]);
    it.en  = modelEn;
    it.rd  = '0;
    it.sel = '0;
    it.wr  = '0;
    it.tag = tag;
    if (re) begin
      if (ctrl) it.rd = addr[0] ? modelEn[15:8] : modelEn[7:0];
      else if (modelEn[idx]) it.rd = periphVal(idx);
    end
    if (!ctrl && (we || re) && modelEn[idx]) it.sel = 16'(1) << idx;
    if (!ctrl && we && modelEn[idx]) it.wr = 16'(1) << idx;
    scoreQ.push_back(it);
    -> sampleEv;
    if (we && ctrl) begin
      if (addr[0]) modelEn[15:8] = wd;
      else modelEn[7:0] = wd;
    end
  endtask

  // Monitor: compare design outputs against the queued expectation
  initial begin
    forever begin
      expItem_t e;
      @(sampleEv);
      #1;
      e = scoreQ.pop_front();
      vecCount++;
      if (busRdData !== e.rd || periphSel !== e.sel ||
          periphWrEn !== e.wr || periphClkEn !== e.en) begin
        failCount++;
        $display("FAIL %s: rd=%h sel=%h wr=%h en=%h expected rd=%h sel=%h wr=%h en=%h",
                 e.tag, busRdData, periphSel, periphWrEn, periphClkEn,
                 e.rd, e.sel, e.wr, e.en);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) periphRdData[i*8 +: 8] = periphVal(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    applyVec(8'h80, 8'h00, 0, 1, "R1 reset reg0 reads zero");
    applyVec(8'h81, 8'h00, 0, 1, "R1 reset reg1 reads zero");
    applyVec(8'h18, 8'h00, 0, 1, "R6 read disabled periph3 gives zero");
    applyVec(8'h18, 8'h55, 1, 0, "R5 write to disabled periph3 dropped");
    applyVec(8'h80, 8'h0A, 1, 0, "R2 write reg0 enables 1 and 3");
    applyVec(8'h80, 8'h00, 0, 1, "R3 read back reg0 after write");
    applyVec(8'h18, 8'h33, 1, 0, "R4 write forwarded to enabled periph3");
    applyVec(8'h10, 8'h33, 1, 0, "R5 write to disabled periph2 dropped");
    applyVec(8'h08, 8'h00, 0, 1, "R6 read enabled periph1");
    applyVec(8'h00, 8'h00, 0, 1, "R6 read disabled periph0 gives zero");
    applyVec(8'h81, 8'h81, 1, 0, "R2 write reg1 enables 8 and 15");
    applyVec(8'h80, 8'h00, 0, 1, "R9 reg0 unchanged after reg1 write");
    applyVec(8'h81, 8'h00, 0, 1, "R3 read back reg1");
    applyVec(8'h78, 8'hC3, 1, 0, "R4 write forwarded to periph15");
    applyVec(8'h40, 8'h00, 0, 1, "R6 read enabled periph8");
    applyVec(8'hFF, 8'h00, 0, 1, "R8 control offset from bit0 only");
    applyVec(8'hFE, 8'h00, 0, 1, "R8 control offset ignores bits 6:1");
    applyVec(8'h18, 8'h00, 0, 0, "R7 idle cycle selects nothing");
    applyVec(8'h80, 8'h00, 1, 0, "R2 clear reg0");
    applyVec(8'h18, 8'h77, 1, 0, "R5 write dropped after disable");
    applyVec(8'h08, 8'h00, 0, 1, "R7 read of periph1 after disable");
    applyVec(8'h81, 8'h00, 0, 1, "R9 reg1 unchanged after reg0 clear");
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule